// File: doc/BRIEF.md
# Pixel Clock Phase and Reset Controller

This block sits at the front of a video encoder that runs from a master clock at twice the pixel rate. It derives a half-rate pixel enable from that clock and decides where its phase lies. In master mode the phase is fixed by the release of reset. In slave and genlock modes it is pulled into line by a falling edge on the chosen external horizontal sync. A free-running count of master clock edges since reset is exposed so that odd and even edge numbers can be told apart. In master mode the block also emits a line sync pulse that only ever starts on a pixel-enabled edge.

Reset returns the frame position to field 1, line 1. It clears the soft-reset bit of the global control byte and leaves the other seven bits as they were. The hardware option input picks whether the encoder is held powered down while reset is low. On the pixel side, a 24-bit pixel is split into three byte lanes and captured on the rising edge of a load strobe. The next pixel-enabled edge then moves it into the output register of the processing path.

Top module: `pxclk_phase_ctrl`

## Requirements
- R1: While rst_n is sampled low: pix_en is 1, edge_cnt is 0, line_sync is 0, pix_out is 0, field_num is 1 and line_num is 1.
- R2: Each master clock edge with rst_n high adds 1 to edge_cnt, so the first edge after reset release reads 1.
- R3: In master mode (mode_sel 2'b00, and 2'b11 behaves the same), pix_en is 1 exactly in the cycles where edge_cnt is even, so the pixel-enabled edges are the odd-numbered ones. Both sync inputs have no effect on the phase.
- R4: In slave mode (mode_sel 2'b01), slv_sync_n sampled high at one edge and low at the next edge E makes pix_en 1 after edge E+1, two high cycles in a row if needed, and pix_en then alternates. gen_sync_n has no effect in this mode.
- R5: In genlock mode (mode_sel 2'b10), gen_sync_n realigns the phase in the same way as R4.
- R6: In master mode, line_sync is a one-cycle pulse after edge 1 and again after every LINE_PIX pixel-enabled edges. It only rises on odd-numbered edges and stays 0 in slave and genlock modes.
- R7: A pixel is captured only on an edge where pix_ld is sampled high after being low. pix_in[23:16], [15:8] and [7:0] go to three separate byte lanes, and a strobe held high captures nothing more.
- R8: pix_out takes the captured pixel only on an edge where pix_en is 1 and holds otherwise. A capture and a transfer on the same edge move the previous pixel.
- R9: Reset clears ctl_q[4] and keeps ctl_q[7:5] and ctl_q[3:0]. A ctl_we write is taken only while rst_n is high.
- R10: pwr_down follows the inverse of hres_opt while reset is low and returns to 0 on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at twice the pixel rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 00 master, 01 slave, 10 genlock, 11 as master |
| slv_sync_n | input | 1 | External horizontal sync, active low, used in slave mode |
| gen_sync_n | input | 1 | Genlock horizontal sync, active low, used in genlock mode |
| hres_opt | input | 1 | Low: hold power-down during reset |
| ctl_we | input | 1 | Write strobe for the global control byte |
| ctl_wdata | input | 8 | Write data for the global control byte |
| pix_ld | input | 1 | Pixel load strobe, rising edge captures |
| pix_in | input | 24 | Incoming pixel, three bytes |
| pix_en | output | 1 | Half-rate pixel clock enable |
| edge_cnt | output | CNT_W | Master clock edges since reset |
| line_sync | output | 1 | Master-mode line sync pulse |
| pix_out | output | 24 | Pixel moved into the processing path |
| ctl_q | output | 8 | Global control byte |
| pwr_down | output | 1 | Power-down state |
| field_num | output | FLD_W | Field position |
| line_num | output | LINE_W | Line position |

## Verification
Capturing a new pixel and moving the held pixel into the path can land on the same master clock edge. The bench provokes this by raising pix_ld so that it is first sampled high on an odd-numbered edge in master mode, where the pixel enable is also active. It judges the result by requiring pix_out to keep the earlier pixel on that edge and the one after, and to show the new pixel only on the next pixel-enabled edge. A strobe sampled on an even edge serves as the contrast case, where the new pixel must appear one edge later.

// File: rtl/pxc_pkg.sv
// Shared types for the pixel clock phase controller.
// Assumes: mode encoding is fixed by the top-level mode_sel pin.
package pxc_pkg;
    typedef enum logic [1:0] {
        MODE_MASTER  = 2'b00,
        MODE_SLAVE   = 2'b01,
        MODE_GENLOCK = 2'b10,
        MODE_ALT     = 2'b11
    } pxc_mode_e;

    localparam int PXC_LANES  = 3;
    localparam int PXC_LANE_W = 8;
    localparam int PXC_PIX_W  = PXC_LANES * PXC_LANE_W;
endpackage

// File: rtl/pxc_phase_gen.sv
// Edge counter and divide-by-two pixel enable generator.
// The enable starts high while in reset, so the first edge after release
// is pixel-enabled. In slave/genlock mode a sync falling edge detected on
// edge E forces the enable high for the edge after E+1.
// Assumes: sync inputs are already synchronous to clk.
module pxc_phase_gen
    import pxc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pxc_mode_e        mode,
    input  logic             slv_sync_n,
    input  logic             gen_sync_n,
    output logic             pix_en,
    output logic [CNT_W-1:0] edge_cnt
);
    logic lock_mode;
    logic sync_sel;
    logic sync_q;
    logic fall_d;

    // Pick the sync that steers the phase in the current mode.
    always_comb begin
        lock_mode = 1'b0;
        sync_sel  = 1'b1;
        case (mode)
            MODE_SLAVE: begin
                lock_mode = 1'b1;
                sync_sel  = slv_sync_n;
            end
            MODE_GENLOCK: begin
                lock_mode = 1'b1;
                sync_sel  = gen_sync_n;
            end
            default: begin
                lock_mode = 1'b0;
                sync_sel  = 1'b1;
            end
        endcase
    end

    // Count master clock edges since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_cnt <= '0;
        else        edge_cnt <= edge_cnt + 1'b1;
    end

    // Track the selected sync and flag a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b1;
            fall_d <= 1'b0;
        end else begin
            sync_q <= sync_sel;
            fall_d <= lock_mode & sync_q & ~sync_sel;
        end
    end

    // Toggle the pixel enable, or force it high to realign.
    always_ff @(posedge clk) begin
        if (!rst_n)      pix_en <= 1'b1;
        else if (fall_d) pix_en <= 1'b1;
        else             pix_en <= ~pix_en;
    end
endmodule

// File: rtl/pxc_sync_out.sv
// Master-mode line sync: a one-cycle pulse on the first pixel-enabled edge
// after reset and then every LINE_PIX pixel-enabled edges.
// Assumes: pix_en comes from pxc_phase_gen.
module pxc_sync_out #(
    parameter int LINE_PIX = 858
) (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic pix_en,
    output logic line_sync
);
    localparam int PX_W = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1;
    localparam logic [PX_W-1:0] PX_LAST = PX_W'(LINE_PIX - 1);

    logic [PX_W-1:0] px_cnt;
    logic            px_step;

    assign px_step = is_master & pix_en;

    // Pixel position within the line, master mode only.
    always_ff @(posedge clk) begin
        if (!rst_n)       px_cnt <= '0;
        else if (px_step) px_cnt <= (px_cnt == PX_LAST) ? '0 : px_cnt + 1'b1;
    end

    // Emit the pulse at pixel 0 of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) line_sync <= 1'b0;
        else        line_sync <= px_step && (px_cnt == '0);
    end
endmodule

// File: rtl/pxc_pixel_latch.sv
// Pixel input stage: byte lanes captured on a rising load strobe, then
// moved into the path register on a pixel-enabled edge.
// Assumes: pix_ld is synchronous to clk and held for at least one edge.
module pxc_pixel_latch
    import pxc_pkg::*;
#(
    parameter int LANES  = PXC_LANES,
    parameter int LANE_W = PXC_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_en,
    input  logic                    pix_ld,
    input  logic [LANES*LANE_W-1:0] pix_in,
    output logic [LANES*LANE_W-1:0] pix_out
);
    localparam int BUS_W = LANES * LANE_W;

    logic             ld_q;
    logic             ld_rise;
    logic [BUS_W-1:0] cap_bus;

    assign ld_rise = pix_ld & ~ld_q;

    // Remember the strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_q <= 1'b0;
        else        ld_q <= pix_ld;
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        logic [LANE_W-1:0] cap_b;

        // Capture one byte lane on a strobe rise.
        always_ff @(posedge clk) begin
            if (!rst_n)       cap_b <= '0;
            else if (ld_rise) cap_b <= pix_in[ln*LANE_W +: LANE_W];
        end

        assign cap_bus[ln*LANE_W +: LANE_W] = cap_b;
    end

    // Move the held pixel into the path on a pixel edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      pix_out <= '0;
        else if (pix_en) pix_out <= cap_bus;
    end
endmodule

// File: rtl/pxc_reset_ctl.sv
// Reset side effects: frame position to field 1 line 1, soft-reset bit
// cleared, power-down held according to the hardware option input.
// The other control bits carry no reset and survive it.
// Assumes: writes arrive synchronous to clk.
module pxc_reset_ctl #(
    parameter int CTL_W    = 8,
    parameter int SRST_BIT = 4,
    parameter int FLD_W    = 2,
    parameter int LINE_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hres_opt,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              pwr_down,
    output logic [FLD_W-1:0]  field_num,
    output logic [LINE_W-1:0] line_num
);
    // Control byte: writes only out of reset, reset touches one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q[SRST_BIT] <= 1'b0;
        else if (ctl_we) ctl_q <= ctl_wdata;
    end

    // Power-down is held during reset when the option input is low.
    always_ff @(posedge clk) begin
        if (!rst_n) pwr_down <= ~hres_opt;
        else        pwr_down <= 1'b0;
    end

    // Frame position returns to the first line of field 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_num <= FLD_W'(1);
            line_num  <= LINE_W'(1);
        end
    end
endmodule

// File: rtl/pxclk_phase_ctrl.sv
// Top: pixel clock phase and reset controller.
// Wires the phase generator, master line sync, pixel input stage and reset
// side effects together. Assumes all inputs are synchronous to clk.
module pxclk_phase_ctrl
    import pxc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int LINE_PIX = 858,
    parameter int FLD_W    = 2,
    parameter int LINE_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              slv_sync_n,
    input  logic              gen_sync_n,
    input  logic              hres_opt,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              pix_ld,
    input  logic [23:0]       pix_in,
    output logic              pix_en,
    output logic [CNT_W-1:0]  edge_cnt,
    output logic              line_sync,
    output logic [23:0]       pix_out,
    output logic [7:0]        ctl_q,
    output logic              pwr_down,
    output logic [FLD_W-1:0]  field_num,
    output logic [LINE_W-1:0] line_num
);
    pxc_mode_e mode_e;
    logic      is_master;

    assign mode_e    = pxc_mode_e'(mode_sel);
    assign is_master = (mode_e == MODE_MASTER) || (mode_e == MODE_ALT);

    pxc_phase_gen #(.CNT_W(CNT_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_e),
        .slv_sync_n (slv_sync_n),
        .gen_sync_n (gen_sync_n),
        .pix_en     (pix_en),
        .edge_cnt   (edge_cnt)
    );

    pxc_sync_out #(.LINE_PIX(LINE_PIX)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .pix_en    (pix_en),
        .line_sync (line_sync)
    );

    pxc_pixel_latch #(.LANES(PXC_LANES), .LANE_W(PXC_LANE_W)) u_pix (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_en  (pix_en),
        .pix_ld  (pix_ld),
        .pix_in  (pix_in),
        .pix_out (pix_out)
    );

    pxc_reset_ctl #(.CTL_W(8), .SRST_BIT(4), .FLD_W(FLD_W), .LINE_W(LINE_W)) u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .hres_opt  (hres_opt),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_q     (ctl_q),
        .pwr_down  (pwr_down),
        .field_num (field_num),
        .line_num  (line_num)
    );
endmodule

// File: rtl/pxc_chk.sv
// Property checker for pxclk_phase_ctrl, attached by bind below.
// Assumes: bench starts with reset low at time zero.
module pxc_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             slv_sync_n,
    input logic             gen_sync_n,
    input logic             hres_opt,
    input logic             ctl_we,
    input logic             pix_en,
    input logic [CNT_W-1:0] edge_cnt,
    input logic             line_sync,
    input logic [23:0]      pix_out,
    input logic [7:0]       ctl_q,
    input logic             pwr_down
);
    localparam logic [7:0] KEEP_MASK = 8'hEF;

    logic       lock_sync;
    logic       lock_mode;
    logic       m_run;
    logic       p_rst;
    logic       p_seen;
    logic       p_valid;
    logic       p_hres;
    logic [7:0] p_ctl;

    // Sync that should steer the phase in the current mode.
    always_comb begin
        lock_mode = (mode_sel == 2'b01) || (mode_sel == 2'b10);
        lock_sync = (mode_sel == 2'b01) ? slv_sync_n :
                    (mode_sel == 2'b10) ? gen_sync_n : 1'b1;
    end

    // Track a master run started from reset.
    always_ff @(posedge clk) begin
        if (!rst_n) m_run <= !lock_mode;
        else        m_run <= m_run && !lock_mode;
    end

    // History for the reset-side checks.
    always_ff @(posedge clk) begin
        p_rst   <= rst_n;
        p_ctl   <= ctl_q;
        p_hres  <= hres_opt;
        p_valid <= 1'b1;
        if (rst_n && ctl_we) p_seen <= 1'b1;
        else if (!p_valid)   p_seen <= 1'b0;
    end

    // Immediate checks on reset side effects.
    always_ff @(posedge clk) begin
        if (p_seen && !p_rst) begin
            // R9
            ctl_keep_chk: assert (((ctl_q & KEEP_MASK) == (p_ctl & KEEP_MASK)) && !ctl_q[4])
                else $error("ctl byte changed by reset");
        end
        if (p_valid && !p_rst) begin
            // R10
            pwr_hold_chk: assert (pwr_down == !p_hres)
                else $error("power-down does not follow option");
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> edge_cnt == $past(edge_cnt) + 1'b1);

    // R3
    master_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_run |-> pix_en == !edge_cnt[0]);

    // R4
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2) && $past(lock_mode, 2) &&
         $past(mode_sel, 3) == $past(mode_sel, 2) &&
         $past(lock_sync, 3) && !$past(lock_sync, 2)) |-> pix_en);

    // R6
    sync_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_sync) |-> edge_cnt[0]);

    // R6
    sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_mode |=> !line_sync);

    // R8
    path_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pix_en)) |-> $stable(pix_out));
endmodule

bind pxclk_phase_ctrl pxc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .slv_sync_n (slv_sync_n),
    .gen_sync_n (gen_sync_n),
    .hres_opt   (hres_opt),
    .ctl_we     (ctl_we),
    .pix_en     (pix_en),
    .edge_cnt   (edge_cnt),
    .line_sync  (line_sync),
    .pix_out    (pix_out),
    .ctl_q      (ctl_q),
    .pwr_down   (pwr_down)
);

// File: tb/sim_pxclk_phase_ctrl.sv
// Scoreboard bench: the stimulus pushes expected values tagged with the
// cycle they are due in; a monitor pops and compares them at negedge.
module sim_pxclk_phase_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int LINE_PIX   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode_sel = 2'b00;
    logic              slv_sync_n = 1'b1;
    logic              gen_sync_n = 1'b1;
    logic              hres_opt = 1'b0;
    logic              ctl_we = 1'b0;
    logic [7:0]        ctl_wdata = 8'h00;
    logic              pix_ld = 1'b0;
    logic [23:0]       pix_in = 24'h0;
    logic              pix_en;
    logic [CNT_W-1:0]  edge_cnt;
    logic              line_sync;
    logic [23:0]       pix_out;
    logic [7:0]        ctl_q;
    logic              pwr_down;
    logic [1:0]        field_num;
    logic [9:0]        line_num;

    typedef struct {
        int          cyc;
        int          sig;
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    pxclk_phase_ctrl #(.CNT_W(CNT_W), .LINE_PIX(LINE_PIX)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .slv_sync_n(slv_sync_n), .gen_sync_n(gen_sync_n), .hres_opt(hres_opt),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .pix_ld(pix_ld), .pix_in(pix_in),
        .pix_en(pix_en), .edge_cnt(edge_cnt), .line_sync(line_sync),
        .pix_out(pix_out), .ctl_q(ctl_q), .pwr_down(pwr_down),
        .field_num(field_num), .line_num(line_num)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] get_sig(int id);
        case (id)
            0: return 32'(pix_en);
            1: return 32'(edge_cnt);
            2: return 32'(line_sync);
            3: return 32'(pix_out);
            4: return 32'(ctl_q);
            5: return 32'(pwr_down);
            6: return 32'(field_num);
            default: return 32'(line_num);
        endcase
    endfunction

    // Driver side: queue an expected value for a future cycle.
    task automatic expect_at(int at, int id, logic [31:0] v, string tag);
        exp_t e;
        e.cyc = at; e.sig = id; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                logic [31:0] act;
                act = get_sig(sb[i].sig);
                checks++;
                if (act !== sb[i].val) begin
                    failures++;
                    $display("FAIL %s sig%0d cyc%0d actual=%0h expected=%0h",
                             sb[i].tag, sb[i].sig, cyc, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic finish_run();
        if (sb.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r;
        int r2;
        int r3;
        // R1, R10: reset state with power-down option low
        wait_cyc(3);
        expect_at(4, 0, 1, "R1");
        expect_at(4, 1, 0, "R1");
        expect_at(4, 2, 0, "R1");
        expect_at(4, 3, 0, "R1");
        expect_at(4, 6, 1, "R1");
        expect_at(4, 7, 1, "R1");
        expect_at(4, 5, 1, "R10");
        wait_cyc(5);
        rst_n = 1'b1;
        r = cyc;
        // R2, R3, R10: master phase from reset release
        expect_at(r + 1, 1, 1, "R2");
        expect_at(r + 1, 0, 0, "R3");
        expect_at(r + 2, 0, 1, "R3");
        expect_at(r + 3, 0, 0, "R3");
        expect_at(r + 1, 5, 0, "R10");
        expect_at(r + 11, 1, 11, "R2");
        // R6: line sync after edge 1 and LINE_PIX pixel edges later
        expect_at(r + 1, 2, 1, "R6");
        expect_at(r + 2, 2, 0, "R6");
        expect_at(r + 10, 2, 0, "R6");
        expect_at(r + 11, 2, 1, "R6");
        expect_at(r + 12, 2, 0, "R6");
        // R7, R8: strobe sampled at even edge 4
        wait_cyc(r + 3);
        pix_in = 24'hA1B2C3; pix_ld = 1'b1;
        expect_at(r + 4, 3, 24'h0, "R8");
        expect_at(r + 5, 3, 24'hA1B2C3, "R7");
        wait_cyc(r + 4);
        pix_ld = 1'b0;
        wait_cyc(r + 5);
        pix_in = 24'h3C4D5E; pix_ld = 1'b1;
        expect_at(r + 6, 3, 24'hA1B2C3, "R8");
        expect_at(r + 7, 3, 24'h3C4D5E, "R7");
        wait_cyc(r + 6);
        pix_ld = 1'b0;
        // R8: capture and transfer on the same odd edge 9
        wait_cyc(r + 8);
        pix_in = 24'h0F1E2D; pix_ld = 1'b1;
        expect_at(r + 9, 3, 24'h3C4D5E, "R8");
        expect_at(r + 10, 3, 24'h3C4D5E, "R8");
        expect_at(r + 11, 3, 24'h0F1E2D, "R8");
        wait_cyc(r + 9);
        pix_ld = 1'b0;
        // R7: strobe held high captures only on its rise
        wait_cyc(r + 12);
        pix_in = 24'h112233; pix_ld = 1'b1;
        wait_cyc(r + 13);
        pix_in = 24'h998877;
        expect_at(r + 15, 3, 24'h112233, "R7");
        expect_at(r + 17, 3, 24'h112233, "R7");
        wait_cyc(r + 14);
        pix_ld = 1'b0;
        // R3: slave sync ignored in master mode
        wait_cyc(r + 15);
        slv_sync_n = 1'b0;
        expect_at(r + 16, 0, 1, "R3");
        expect_at(r + 17, 0, 0, "R3");
        wait_cyc(r + 18);
        slv_sync_n = 1'b1;
        // R9: write, then reset clears only the soft-reset bit
        wait_cyc(r + 20);
        ctl_we = 1'b1; ctl_wdata = 8'hFF;
        expect_at(r + 21, 4, 8'hFF, "R9");
        wait_cyc(r + 21);
        ctl_we = 1'b0;
        wait_cyc(r + 22);
        rst_n = 1'b0; hres_opt = 1'b1; mode_sel = 2'b01;
        expect_at(r + 23, 4, 8'hEF, "R9");
        expect_at(r + 23, 5, 0, "R10");
        wait_cyc(r + 23);
        ctl_we = 1'b1; ctl_wdata = 8'h00;
        expect_at(r + 24, 4, 8'hEF, "R9");
        wait_cyc(r + 24);
        ctl_we = 1'b0;
        wait_cyc(r + 25);
        rst_n = 1'b1;
        r2 = cyc;
        // R4: slave realign, forced high after edge 5
        expect_at(r2 + 1, 0, 0, "R4");
        expect_at(r2 + 1, 2, 0, "R6");
        expect_at(r2 + 2, 0, 1, "R4");
        wait_cyc(r2 + 3);
        slv_sync_n = 1'b0;
        expect_at(r2 + 4, 0, 1, "R4");
        expect_at(r2 + 5, 0, 1, "R4");
        expect_at(r2 + 6, 0, 0, "R4");
        expect_at(r2 + 7, 0, 1, "R4");
        wait_cyc(r2 + 6);
        slv_sync_n = 1'b1;
        // R4: genlock sync ignored in slave mode
        wait_cyc(r2 + 8);
        gen_sync_n = 1'b0;
        expect_at(r2 + 10, 0, 0, "R4");
        expect_at(r2 + 11, 0, 1, "R4");
        expect_at(r2 + 11, 2, 0, "R6");
        wait_cyc(r2 + 12);
        gen_sync_n = 1'b1;
        // R5: genlock realign
        wait_cyc(r2 + 13);
        rst_n = 1'b0; mode_sel = 2'b10;
        wait_cyc(r2 + 15);
        rst_n = 1'b1;
        r3 = cyc;
        wait_cyc(r3 + 3);
        gen_sync_n = 1'b0;
        expect_at(r3 + 4, 0, 1, "R5");
        expect_at(r3 + 5, 0, 1, "R5");
        expect_at(r3 + 6, 0, 0, "R5");
        expect_at(r3 + 5, 1, 5, "R2");
        wait_cyc(r3 + 6);
        gen_sync_n = 1'b1;
        wait_cyc(r3 + 10);
        done = 1'b1;
        finish_run();
    end
endmodule